// File: doc/BRIEF.md
# Logic and Shift Execution Unit

This block is a single-stage 32-bit execution unit for the bitwise side of a processor datapath. Each accepted request picks one of seven operations (AND, OR, XOR, arithmetic shift right, logical shift right, logical shift left, bit reverse). The first operand always comes from `src_a`. The second operand comes either from the register operand `src_b` or from a zero-extended 5-bit immediate, as chosen by `use_imm`.

A request is presented with `req_valid` high. On that clock edge the block registers the result and four condition flags: negative, zero, carry and overflow. It pulses `rsp_valid` for one cycle. The flag policy is fixed. Negative mirrors bit 31 of the result, zero reports an all-zero result, and carry and overflow are always cleared.

The one operation code the block does not support is rejected. That request leaves the result and the flags as they were and pulses `rsp_illegal`.

Top module: `logic_shift_unit`

## Requirements
- R1: With `op_code` 0, 1 or 2, the result is `src_a` AND, OR or XOR (respectively) the second operand.
- R2: When `use_imm` is 1, the second operand is `imm5` zero-extended to 32 bits. When `use_imm` is 0, it is `src_b`.
- R3: For the shift codes (3, 4, 5), the shift distance is bits [4:0] of the second operand, and higher bits of the second operand are ignored.
- R4: Code 3 (arithmetic right shift) fills the vacated upper bits with bit 31 of `src_a`. Code 4 (logical right shift) fills them with zeros.
- R5: Code 5 (left shift) fills the low bits with zeros and drops every bit moved past bit 31.
- R6: Code 6 (bit reverse) puts bit i of `src_a` at result bit 31-i, for i from 0 to 31. It ignores the second operand.
- R7: After an accepted operation, `flag_n` equals result bit 31, and `flag_z` is 1 exactly when all 32 result bits are zero.
- R8: `flag_c` and `flag_v` read 0 after every accepted operation.
- R9: The result and the flags change only at a clock edge where `req_valid` is 1. They appear one cycle later together with a one-cycle `rsp_valid` pulse. Without `req_valid`, `rsp_valid` stays 0 and the outputs hold.
- R10: Code 7 is illegal. A request carrying it leaves the result and all flags unchanged, keeps `rsp_valid` at 0, and raises `rsp_illegal` for exactly the following cycle.
- R11: While `rst_n` is low, the result, all four flags, `rsp_valid` and `rsp_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op_code | input | 3 | Operation select (0 AND, 1 OR, 2 XOR, 3 ASR, 4 LSR, 5 LSL, 6 reverse, 7 illegal) |
| use_imm | input | 1 | Select immediate as second operand |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Register second operand |
| imm5 | input | 5 | Immediate second operand |
| rsp_valid | output | 1 | Result and flags updated this cycle |
| rsp_illegal | output | 1 | Previous request carried an illegal code |
| result | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (always cleared) |
| flag_v | output | 1 | Overflow flag (always cleared) |

## Verification
The assertions take for granted that `req_valid` and `op_code` are settled at each rising edge. They also assume that operands change only between requests, so the value sampled for a bit-reverse request is the one the datapath used. The stimulus meets this by changing every input on the falling edge only. It mixes back-to-back requests, idle gaps and illegal codes, so the hold and pulse rules are exercised right next to real updates. Operands with high bits set in the register path show that only the low five bits steer a shift.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_LSR  = 3'd4,
    OP_LSL  = 3'd5,
    OP_REV  = 3'd6,
    OP_RSVD = 3'd7
  } lsu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } sh_mode_e;

endpackage

// File: rtl/lsu_operand_sel.sv
module lsu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd
);

  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (use_imm) begin
      opnd = {{PAD_W{1'b0}}, imm_val};
    end else begin
      opnd = reg_val;
    end
  end

endmodule

// File: rtl/lsu_barrel_shifter.sv
module lsu_barrel_shifter
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  sh_mode_e           mode,
  output logic [DATA_W-1:0]  dout
);

  logic fill_bit;

  assign fill_bit = (mode == SH_RARI) & din[DATA_W-1];

  // Logarithmic stages: stage k moves the word by 2**k when amt[k] is set.
  always_comb begin
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] fill_mask;
    cur = din;
    for (int k = 0; k < SHAMT_W; k++) begin
      fill_mask = ~({DATA_W{1'b1}} >> (1 << k));
      if (amt[k]) begin
        if (mode == SH_LEFT) begin
          cur = cur << (1 << k);
        end else begin
          cur = (cur >> (1 << k)) | (fill_bit ? fill_mask : '0);
        end
      end
    end
    dout = cur;
  end

endmodule

// File: rtl/lsu_bit_reverser.sv
module lsu_bit_reverser #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_swap
    assign dout[DATA_W-1-i] = din[i];
  end

endmodule

// File: rtl/logic_shift_unit.sv
module logic_shift_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        op_code,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm5,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);

  localparam int SHAMT_W = $clog2(DATA_W);

  lsu_op_e           op;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] rev_out;
  sh_mode_e          sh_mode;
  logic [DATA_W-1:0] alu_res;
  logic              legal;
  logic              load;

  logic [DATA_W-1:0] res_q, res_d;
  logic              n_q, n_d, z_q, z_d, c_q, c_d, v_q, v_d;
  logic              vld_q, vld_d, ill_q, ill_d;

  assign op = lsu_op_e'(op_code);

  lsu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_imm (use_imm),
    .reg_val (src_b),
    .imm_val (imm5),
    .opnd    (opnd_b)
  );

  always_comb begin
    case (op)
      OP_ASR:  sh_mode = SH_RARI;
      OP_LSR:  sh_mode = SH_RLOG;
      default: sh_mode = SH_LEFT;
    endcase
  end

  lsu_barrel_shifter #(.DATA_W(DATA_W)) u_shift (
    .din  (src_a),
    .amt  (opnd_b[SHAMT_W-1:0]),
    .mode (sh_mode),
    .dout (sh_out)
  );

  lsu_bit_reverser #(.DATA_W(DATA_W)) u_rev (
    .din  (src_a),
    .dout (rev_out)
  );

  always_comb begin
    legal = 1'b1;
    case (op)
      OP_AND:  alu_res = src_a & opnd_b;
      OP_OR:   alu_res = src_a | opnd_b;
      OP_XOR:  alu_res = src_a ^ opnd_b;
      OP_ASR,
      OP_LSR,
      OP_LSL:  alu_res = sh_out;
      OP_REV:  alu_res = rev_out;
      default: begin
        alu_res = res_q;
        legal   = 1'b0;
      end
    endcase
  end

  assign load = req_valid & legal;

  // Next-state
  always_comb begin
    res_d = res_q;
    n_d   = n_q;
    z_d   = z_q;
    c_d   = c_q;
    v_d   = v_q;
    if (load) begin
      res_d = alu_res;
      n_d   = alu_res[DATA_W-1];
      z_d   = (alu_res == '0);
      c_d   = 1'b0;
      v_d   = 1'b0;
    end
    vld_d = load;
    ill_d = req_valid & ~legal;
  end

  // State
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
      v_q   <= 1'b0;
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      res_q <= res_d;
      n_q   <= n_d;
      z_q   <= z_d;
      c_q   <= c_d;
      v_q   <= v_d;
      vld_q <= vld_d;
      ill_q <= ill_d;
    end
  end

  assign result      = res_q;
  assign flag_n      = n_q;
  assign flag_z      = z_q;
  assign flag_c      = c_q;
  assign flag_v      = v_q;
  assign rsp_valid   = vld_q;
  assign rsp_illegal = ill_q;

endmodule

// File: rtl/logic_shift_unit_chk.sv
module logic_shift_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] src_a,
  input logic              rsp_valid,
  input logic              rsp_illegal,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);

  function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    for (int i = 0; i < DATA_W; i++) y[i] = x[DATA_W-1-i];
    return y;
  endfunction

  // R6
  rev_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_code == 3'd6) |=> (result == mirror($past(src_a))));

  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (flag_n == result[DATA_W-1]));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (flag_z == (result == '0)));

  // R8
  no_carry_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!flag_c && !flag_v));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(result) && $stable(flag_n) && $stable(flag_z)));

  // R10
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_code == 3'd7) |=> (rsp_illegal && !rsp_valid));

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> ($stable(result) && $stable(flag_n) && $stable(flag_z)
                     && $stable(flag_c) && $stable(flag_v)));

  // R9
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, rsp_illegal}));

endmodule

bind logic_shift_unit logic_shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .op_code     (op_code),
  .src_a       (src_a),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .result      (result),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .flag_v      (flag_v)
);

// File: tb/logic_shift_unit_tb.sv
module logic_shift_unit_tb;

  typedef struct {
    logic [31:0] res;
    logic        n;
    logic        z;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  op_code;
  logic        use_imm;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [4:0]  imm5;
  logic        rsp_valid;
  logic        rsp_illegal;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  exp_t        sb[$];
  logic [31:0] m_res;
  logic        m_n, m_z;
  logic        run_done = 1'b0;

  logic_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_code(op_code),
    .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm5(imm5),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic [4:0]  s;
    s = b[4:0];
    case (op)
      3'd0: r = a & b;
      3'd1: r = a | b;
      3'd2: r = a ^ b;
      3'd3: r = $unsigned($signed(a) >>> s);
      3'd4: r = a >> s;
      3'd5: r = a << s;
      3'd6: begin
        r = '0;
        for (int i = 0; i < 32; i++) if (a[i]) r[31-i] = 1'b1;
      end
      default: r = m_res;
    endcase
    return r;
  endfunction

  task automatic drive(input logic [2:0] op, input logic isel, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] im, input string tag);
    exp_t e;
    logic [31:0] opb;
    @(negedge clk);
    req_valid = 1'b1; op_code = op; use_imm = isel;
    src_a = a; src_b = b; imm5 = im;
    opb = isel ? {27'd0, im} : b;
    if (op != 3'd7) begin
      m_res = model(op, a, opb);
      m_n   = m_res[31];
      m_z   = (m_res == 32'd0);
    end
    e.res = m_res; e.n = m_n; e.z = m_z; e.ill = (op == 3'd7); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      op_code   = 3'd5;
      src_a     = 32'hFFFF_FFFF;
    end
  endtask

  // Monitor: scoreboard comparison shortly after each rising edge
  initial begin
    exp_t e;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #5;
      if (rsp_valid || rsp_illegal) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected response", {62'd0, rsp_valid, rsp_illegal}, 64'd0);
        end else begin
          e = sb.pop_front();
          check(result == e.res, {e.tag, " result"}, {32'd0, result}, {32'd0, e.res});
          check(flag_n == e.n, "R7 negative flag", {63'd0, flag_n}, {63'd0, e.n});
          check(flag_z == e.z, "R7 zero flag", {63'd0, flag_z}, {63'd0, e.z});
          check(!flag_c && !flag_v, "R8 carry/overflow", {62'd0, flag_c, flag_v}, 64'd0);
          check(rsp_illegal == e.ill, "R10 illegal indication", {63'd0, rsp_illegal}, {63'd0, e.ill});
        end
      end else if (sb.size() == 0 && !run_done) begin
        check(result == m_res && flag_n == m_n && flag_z == m_z,
              "R9 hold while idle", {30'd0, flag_n, flag_z, result}, {30'd0, m_n, m_z, m_res});
      end else if (sb.size() != 0) begin
        check(1'b0, "R9 missing response", 64'd0, 64'd1);
        void'(sb.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; op_code = 3'd0; use_imm = 1'b0;
    src_a = '0; src_b = '0; imm5 = '0;
    m_res = '0; m_n = 1'b0; m_z = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R11 reset state
    check(result == 32'd0 && !flag_n && !flag_z && !flag_c && !flag_v && !rsp_valid && !rsp_illegal,
          "R11 reset state", {25'd0, rsp_valid, rsp_illegal, flag_n, flag_z, flag_c, flag_v, result}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 logic operations, R2 operand select
    drive(3'd0, 1'b0, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0,  "R1 and reg");
    drive(3'd1, 1'b0, 32'h8000_0001, 32'h0000_0F00, 5'd0,  "R1 or reg");
    drive(3'd2, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0,  "R1 xor to zero");
    drive(3'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'h15, "R2 and imm");
    drive(3'd1, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 5'h1F, "R2 or imm");
    idle(2);
    // R3 shift amount uses low 5 bits
    drive(3'd4, 1'b0, 32'h8000_0000, 32'hFFFF_FFE3, 5'd0,  "R3 lsr high bits ignored");
    drive(3'd5, 1'b0, 32'h0000_0001, 32'h0000_0020, 5'd0,  "R3 lsl by 32 is by 0");
    // R4 arithmetic vs logical right
    drive(3'd3, 1'b1, 32'h8000_00F0, 32'd0, 5'd4,          "R4 asr negative");
    drive(3'd3, 1'b1, 32'h7000_00F0, 32'd0, 5'd31,         "R4 asr positive to zero");
    drive(3'd3, 1'b1, 32'hFFFF_FFFF, 32'd0, 5'd31,         "R4 asr all ones");
    drive(3'd4, 1'b1, 32'hFFFF_FFFF, 32'd0, 5'd31,         "R4 lsr zero fill");
    // R5 left shift truncation
    drive(3'd5, 1'b1, 32'hC000_0003, 32'd0, 5'd1,          "R5 lsl drops msb");
    drive(3'd5, 1'b1, 32'hFFFF_FFFE, 32'd0, 5'd31,         "R5 lsl to zero");
    idle(1);
    // R6 bit reverse
    drive(3'd6, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 5'd0,  "R6 reverse lsb");
    drive(3'd6, 1'b1, 32'h1234_5678, 32'd0, 5'd7,          "R6 reverse pattern");
    drive(3'd6, 1'b0, 32'h0000_0000, 32'h1234_5678, 5'd0,  "R6 reverse zero");
    idle(1);
    // R10 illegal code holds state
    drive(3'd4, 1'b1, 32'h8000_0000, 32'd0, 5'd0,          "R10 setup");
    drive(3'd7, 1'b0, 32'h0000_0000, 32'h0000_0000, 5'd0,  "R10 illegal hold");
    drive(3'd7, 1'b1, 32'h1111_1111, 32'd0, 5'd3,          "R10 illegal repeat");
    idle(3);
    drive(3'd2, 1'b0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 5'd0,  "R1 xor after illegal");
    idle(3);

    run_done = 1'b1;
    check(sb.size() == 0, "R9 all responses seen", sb.size(), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule